// File: doc/BRIEF.md
# Handshaked Asynchronous Serial Transmitter

This block sends one parallel word per request over an asynchronous serial line, and it holds each word back until the far end grants permission through a request/clear-to-send pair. The user raises a level-style request and sees a `sent` flag fall while the word is in flight. The flag rises again once the frame has left the line and the request has been released.

Two cooperating state machines do the work. A front controller turns the level request into an internal start strobe and follows the engine's done signal through a fixed sequence of steps. A frame engine asserts its request line and waits for clear-to-send. It then sends a low start bit, eight payload bits with the least significant bit first, and one or two high stop bits. Every bit lasts sixteen ticks of an external 16x-baud enable. In parity mode the eighth payload bit carries a computed parity bit in place of input bit 7.

Top module: `uart_hs_tx`

## Requirements
- R1: After reset, and whenever no frame is pending, `txd` is 1 (mark), `rts` is 0 and `sent` is 1.
- R2: When `go` is raised while idle, `sent` falls to 0 and `rts` rises to 1 within a few clock cycles.
- R3: While `cts` is 0 after a request, `txd` stays 1. The start bit (`txd` = 0) begins only on a tick after `cts` has been seen high while `rts` is 1.
- R4: Every bit on `txd` lasts exactly 16 ticks of `tick16`, and `txd` changes only at a clock edge where `tick16` was 1.
- R5: With `par_en` = 0, the eight payload bits are `data_in[0]` first through `data_in[7]` last.
- R6: With `par_en` = 1, the payload is `data_in[0]`..`data_in[6]` followed by a parity bit equal to the XOR of `data_in[6:0]` and `par_odd`. Here `par_odd` = 0 gives even parity, `par_odd` = 1 gives odd parity, and `data_in[7]` is ignored.
- R7: After the payload `txd` is 1 for one bit time when `two_stop` = 0, and for two bit times when `two_stop` = 1.
- R8: At the end of the last stop bit `rts` returns to 0 and the transmitter is idle again.
- R9: `sent` returns to 1 only once the frame has finished and `go` is 0. While `go` is still held after the frame, `sent` stays 0.
- R10: `data_in`, `par_en`, `par_odd` and `two_stop` are captured when the start strobe is accepted. Changes to them during a frame do not alter that frame.
- R11: `cts` is only consulted while waiting to start. Dropping `cts` during a frame does not cut the frame short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | One-cycle enable at 16 times the baud rate |
| go | input | 1 | Level-style send request |
| data_in | input | DATA_W | Word to send |
| par_en | input | 1 | 1: seven data bits plus parity; 0: eight data bits |
| par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| two_stop | input | 1 | 1: two stop bits; 0: one |
| cts | input | 1 | Clear to send from the far end |
| txd | output | 1 | Serial line, idle high |
| rts | output | 1 | Request to send, high from acceptance until the frame ends |
| sent | output | 1 | High when no request is in progress |

## Verification
The bench holds `cts` low for hundreds of cycles after a request. A design that ignored the grant would start its frame early, and the bench would see the line go low. It measures the start bit to the clock against 16 ticks, which catches an off-by-one in the tick counter. It samples bits mid-cell in both framing modes, using a pattern whose bit 7 contradicts the parity, so a wrong bit order, a wrong parity sense or a leaked `data_in[7]` shows up as a bad word. It also changes the inputs and drops `cts` in mid-frame, and it holds `go` past the end of the frame. Each of these exposes a design that samples its inputs late, aborts on `cts`, or reports completion too early.

// File: rtl/uart_hs_pkg.sv
// Shared state encodings for the handshaked serial transmitter.
// Assumes nothing beyond a SystemVerilog-2017 compiler.
package uart_hs_pkg;

    // Front controller: steps of the user request / engine strobe exchange
    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_ARM   = 2'd1,
        FR_PULSE = 2'd2,
        FR_WAIT  = 2'd3
    } front_state_t;

    // Frame engine: line states from idle through the stop bits
    typedef enum logic [2:0] {
        EN_IDLE  = 3'd0,
        EN_READY = 3'd1,
        EN_START = 3'd2,
        EN_DATA  = 3'd3,
        EN_STOP  = 3'd4
    } engine_state_t;

endpackage

// File: rtl/uart_hs_bittimer.sv
// Counts tick enables inside one bit cell and flags the last tick of the cell.
// Assumes tick is a single-cycle enable. While run is low the count is held at
// zero, so the tick on which run rises opens a cell of OVERSAMPLE ticks.
module uart_hs_bittimer #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic cell_end
);
    localparam int CW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);

    logic [CW-1:0] cnt;

    // Tick counter within the current bit cell
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign cell_end = run && tick && (cnt == LAST);

endmodule

// File: rtl/uart_hs_front.sv
// Front controller: turns a level request into a start strobe held until the
// engine drops done, then waits for the engine to finish and the request to be
// released. Assumes done is high whenever the engine is idle.
module uart_hs_front
    import uart_hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic done,
    output logic start_s,
    output logic sent
);
    front_state_t state;

    // Request sequencing: arm, raise strobe, drop strobe, wait completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= FR_IDLE;
            start_s <= 1'b0;
        end else begin
            case (state)
                FR_IDLE:  if (go) state <= FR_ARM;
                FR_ARM:   if (done) begin
                              state   <= FR_PULSE;
                              start_s <= 1'b1;
                          end
                FR_PULSE: if (!done) begin
                              state   <= FR_WAIT;
                              start_s <= 1'b0;
                          end
                FR_WAIT:  if (done && !go) state <= FR_IDLE;
                default:  state <= FR_IDLE;
            endcase
        end
    end

    assign sent = (state == FR_IDLE);

endmodule

// File: rtl/uart_hs_engine.sv
// Frame engine: on a start strobe captures the word and options, raises rts,
// waits for cts on a tick, then shifts start, DATA_W payload bits LSB first
// and one or two stop bits. txd is a register. Assumes DATA_W >= 2.
module uart_hs_engine
    import uart_hs_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start_s,
    input  logic [DATA_W-1:0] data_in,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              cts,
    output logic              done,
    output logic              rts,
    output logic              txd
);
    localparam int IW = $clog2(DATA_W);
    localparam logic [IW-1:0] LAST_IDX = IW'(DATA_W - 1);

    engine_state_t     state;
    logic [DATA_W-1:0] shreg;
    logic [IW-1:0]     idx;
    logic              two_q;
    logic              stop2_q;
    logic              cell_end;
    logic              run;
    logic              par_bit;
    logic [DATA_W-1:0] payload;

    // Payload selection: low bits plus parity, or the full word
    always_comb begin
        par_bit = (^data_in[DATA_W-2:0]) ^ par_odd;
        payload = par_en ? {par_bit, data_in[DATA_W-2:0]} : data_in;
    end

    assign run = (state == EN_START) || (state == EN_DATA) || (state == EN_STOP);

    uart_hs_bittimer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .tick     (tick),
        .cell_end (cell_end)
    );

    // Frame sequencing and the registered line output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= EN_IDLE;
            done    <= 1'b1;
            rts     <= 1'b0;
            txd     <= 1'b1;
            shreg   <= '0;
            idx     <= '0;
            two_q   <= 1'b0;
            stop2_q <= 1'b0;
        end else begin
            case (state)
                EN_IDLE: if (start_s) begin
                    state <= EN_READY;
                    done  <= 1'b0;
                    rts   <= 1'b1;
                    shreg <= payload;
                    two_q <= two_stop;
                end
                EN_READY: if (cts && tick) begin
                    state <= EN_START;
                    txd   <= 1'b0;
                end
                EN_START: if (cell_end) begin
                    state <= EN_DATA;
                    txd   <= shreg[0];
                    shreg <= shreg >> 1;
                    idx   <= '0;
                end
                EN_DATA: if (cell_end) begin
                    if (idx == LAST_IDX) begin
                        state   <= EN_STOP;
                        txd     <= 1'b1;
                        stop2_q <= 1'b0;
                    end else begin
                        txd   <= shreg[0];
                        shreg <= shreg >> 1;
                        idx   <= idx + 1'b1;
                    end
                end
                EN_STOP: if (cell_end) begin
                    if (two_q && !stop2_q) begin
                        stop2_q <= 1'b1;
                    end else begin
                        state <= EN_IDLE;
                        done  <= 1'b1;
                        rts   <= 1'b0;
                    end
                end
                default: state <= EN_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/uart_hs_tx.sv
// Top of the handshaked serial transmitter: front controller plus frame engine.
// Assumes tick16 is a one-cycle enable at 16 times the baud rate.
module uart_hs_tx #(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              go,
    input  logic [DATA_W-1:0] data_in,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              cts,
    output logic              txd,
    output logic              rts,
    output logic              sent
);
    logic start_s;
    logic done_s;

    uart_hs_front u_front (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .done    (done_s),
        .start_s (start_s),
        .sent    (sent)
    );

    uart_hs_engine #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick16),
        .start_s  (start_s),
        .data_in  (data_in),
        .par_en   (par_en),
        .par_odd  (par_odd),
        .two_stop (two_stop),
        .cts      (cts),
        .done     (done_s),
        .rts      (rts),
        .txd      (txd)
    );

endmodule

// File: rtl/uart_hs_tx_chk.sv
// Assertion checker for uart_hs_tx, attached with bind below.
// Assumes synchronous active-low reset on rst_n.
module uart_hs_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tick16,
    input logic cts,
    input logic txd,
    input logic rts,
    input logic sent,
    input logic start_s,
    input logic done_s
);
    logic grant_seen;

    // Remembers that cts was high during the current rts window
    always_ff @(posedge clk) begin
        if (!rst_n || !rts) grant_seen <= 1'b0;
        else if (cts)       grant_seen <= 1'b1;
    end

    // R1
    idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rts |-> txd);

    // R2
    rts_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rts) |-> $past(start_s));

    // R3
    start_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !txd |-> grant_seen);

    // R4
    line_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(txd) |-> $past(tick16));

    // R9
    sent_low_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rts || !done_s) |-> !sent);

endmodule

bind uart_hs_tx uart_hs_tx_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick16  (tick16),
    .cts     (cts),
    .txd     (txd),
    .rts     (rts),
    .sent    (sent),
    .start_s (start_s),
    .done_s  (done_s)
);

// File: tb/uart_hs_tx_test.sv
module uart_hs_tx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16;
    logic       go = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       two_stop = 1'b0;
    logic       cts = 1'b0;
    logic       txd, rts, sent;
    logic [1:0] div = 2'd0;
    int         n_run = 0;
    int         n_fail = 0;
    int         cycles = 0;

    always #2 clk = ~clk;  // 250 MHz

    always @(posedge clk) begin
        div    <= div + 2'd1;
        cycles <= cycles + 1;
    end
    assign tick16 = (div == 2'd3);  // one tick every 4 clocks: 64 clocks per bit

    uart_hs_tx uut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .go(go), .data_in(data_in),
        .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop), .cts(cts),
        .txd(txd), .rts(rts), .sent(sent)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Waits for the start bit, then samples each cell at mid-bit
    task automatic capture(output logic [7:0] b, output logic st, output logic sp1,
                           output logic sp2_txd, output logic sp2_rts);
        int t = 0;
        while (txd !== 1'b0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk("R3 start bit seen", 32'(t < 20000), 32'd1);
        repeat (32) @(negedge clk);
        st = txd;
        for (int i = 0; i < 8; i++) begin
            repeat (64) @(negedge clk);
            b[i] = txd;
        end
        repeat (64) @(negedge clk);
        sp1 = txd;
        repeat (64) @(negedge clk);
        sp2_txd = txd;
        sp2_rts = rts;
    endtask

    task automatic request(input logic [7:0] d, input logic pe, input logic po, input logic ts);
        @(negedge clk);
        data_in = d; par_en = pe; par_odd = po; two_stop = ts;
        go = 1'b1;
        while (sent !== 1'b0) @(negedge clk);
        go = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 reset txd", 32'(txd), 32'd1);
        chk("R1 reset rts", 32'(rts), 32'd0);
        chk("R1 reset sent", 32'(sent), 32'd1);
    endtask

    task automatic t_handshake;
        logic [7:0] b; logic st, s1, s2, r2;
        cts = 1'b0;
        request(8'hA5, 1'b0, 1'b0, 1'b0);
        repeat (10) @(negedge clk);
        chk("R2 sent low", 32'(sent), 32'd0);
        chk("R2 rts high", 32'(rts), 32'd1);
        repeat (300) @(negedge clk);
        chk("R3 line held while cts low", 32'(txd), 32'd1);
        cts = 1'b1;
        capture(b, st, s1, s2, r2);
        chk("R3 start level", 32'(st), 32'd0);
        chk("R5 data lsb first", 32'(b), 32'hA5);
        chk("R7 one stop bit", 32'(s1), 32'd1);
        chk("R8 rts low after one stop", 32'(r2), 32'd0);
        chk("R1 idle mark", 32'(s2), 32'd1);
        chk("R9 sent after frame", 32'(sent), 32'd1);
    endtask

    task automatic t_bitwidth;
        int w = 0;
        int t = 0;
        request(8'h01, 1'b0, 1'b0, 1'b0);
        while (txd !== 1'b0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        while (txd === 1'b0 && w < 1000) begin
            @(negedge clk);
            w++;
        end
        chk("R4 start bit clocks", 32'(w), 32'd64);
        repeat (700) @(negedge clk);
        chk("R8 idle after frame", 32'(rts), 32'd0);
    endtask

    task automatic t_parity;
        logic [7:0] b; logic st, s1, s2, r2;
        request(8'hB1, 1'b1, 1'b0, 1'b0);
        capture(b, st, s1, s2, r2);
        chk("R6 even parity", 32'(b), 32'hB1);
        request(8'hB1, 1'b1, 1'b1, 1'b0);
        capture(b, st, s1, s2, r2);
        chk("R6 odd parity, bit7 ignored", 32'(b), 32'h31);
        request(8'h31, 1'b1, 1'b1, 1'b0);
        capture(b, st, s1, s2, r2);
        chk("R6 odd parity bit zero", 32'(b), 32'h31);
    endtask

    task automatic t_two_stop;
        logic [7:0] b; logic st, s1, s2, r2;
        request(8'h5A, 1'b0, 1'b0, 1'b1);
        capture(b, st, s1, s2, r2);
        chk("R5 data", 32'(b), 32'h5A);
        chk("R7 second stop high", 32'(s2), 32'd1);
        chk("R7 rts through second stop", 32'(r2), 32'd1);
        repeat (64) @(negedge clk);
        chk("R8 rts low after two stops", 32'(rts), 32'd0);
    endtask

    task automatic t_latch;
        logic [7:0] b; logic st, s1, s2, r2;
        request(8'hC3, 1'b0, 1'b0, 1'b0);
        fork
            capture(b, st, s1, s2, r2);
            begin
                while (txd !== 1'b0) @(negedge clk);
                repeat (40) @(negedge clk);
                data_in = 8'h00; par_en = 1'b1; par_odd = 1'b1; two_stop = 1'b1;
            end
        join
        chk("R10 data captured", 32'(b), 32'hC3);
        chk("R10 stop count captured", 32'(r2), 32'd0);
        par_en = 1'b0; par_odd = 1'b0; two_stop = 1'b0;
    endtask

    task automatic t_cts_drop;
        logic [7:0] b; logic st, s1, s2, r2;
        request(8'h96, 1'b0, 1'b0, 1'b0);
        fork
            capture(b, st, s1, s2, r2);
            begin
                while (txd !== 1'b0) @(negedge clk);
                repeat (100) @(negedge clk);
                cts = 1'b0;
            end
        join
        chk("R11 frame completes after cts drop", 32'(b), 32'h96);
        chk("R11 stop after cts drop", 32'(s1), 32'd1);
        cts = 1'b1;
    endtask

    task automatic t_go_hold;
        logic [7:0] b; logic st, s1, s2, r2;
        @(negedge clk);
        data_in = 8'h3C; go = 1'b1;
        capture(b, st, s1, s2, r2);
        chk("R5 held request data", 32'(b), 32'h3C);
        repeat (100) @(negedge clk);
        chk("R9 sent low while go held", 32'(sent), 32'd0);
        chk("R9 no second frame", 32'(txd), 32'd1);
        go = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9 sent after go release", 32'(sent), 32'd1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_handshake();
        t_bitwidth();
        t_parity();
        t_two_stop();
        t_latch();
        t_cts_drop();
        t_go_hold();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        while (cycles < 150000) @(negedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule